// File: doc/BRIEF.md
# Output Slot Source and Drive Selector

This block sits in front of the serial output shifters of a time-slot interchange switch. For each output slot (an output stream and a channel on that stream), the frame sequencer sends a lookup request one channel ahead of that slot's first bit. The block answers with the byte to transmit and with a flag that says whether the slot's output driver should be on. It holds a connection table with one entry per output slot and a receive table with one byte per input slot. The receive table is filled by the input deserialisers.

Each connection entry has a word, a message flag and an enable flag. When the message flag is set, the word itself is sent as a fixed message byte. When it is clear, the word points to an input slot and the byte received there is sent. A global message-mode input makes every slot act as though both of its flags were set. An external drive-enable pin can switch off every driver at once, whatever the other settings are.

Requests travel on a valid/ready channel, and responses leave on another. A request is taken in a cycle where `req_valid` and `req_ready` are both high. A response is consumed in a cycle where `rsp_valid` and `rsp_ready` are both high. While a response is waiting, it and every stage behind it hold their contents. When both stages are full, `req_ready` drops until the response is taken.

Top module: `otsw_out_ctrl`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. Every connection entry reads as switched, disabled and pointing at input slot 0, and every received byte is 0. A lookup made before any write returns byte 0 with `rsp_drive` 0.
- R2: With global message mode 0 and the slot's message flag at 1, the response byte is the slot's stored connection word.
- R3: With global message mode 0 and the slot's message flag at 0, the connection word is read as a source address: bits 7:5 give the input stream and bits 4:0 give the input channel. The response byte is the byte received on that input slot.
- R4: With `msg_all` at 1 in the cycle a request is accepted, the slot sends its stored word as a message and is enabled, whatever flags it actually holds.
- R5: While `drive_en` is 0, `rsp_drive` is 0 in the same cycle, regardless of every other setting.
- R6: While `drive_en` is 1, a response to a request accepted with `msg_all` at 1 has `rsp_drive` at 1.
- R7: While `drive_en` is 1, a response to a request accepted with `msg_all` at 0 has `rsp_drive` equal to the slot's stored enable flag.
- R8: The response to an accepted request appears with `rsp_valid` high two clock edges after acceptance. Responses come out in request order, and at most two requests are in flight.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_byte` and `rsp_valid` hold. With both stages full, `req_ready` is 0.
- R10: A byte written to the receive table is returned by any switched lookup that points at it and is accepted after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_all | input | 1 | Global message mode, sampled when a request is accepted |
| drive_en | input | 1 | External output drive enable; low forces every driver off |
| cm_we | input | 1 | Connection entry write strobe |
| cm_wstream | input | 3 | Output stream of the entry written |
| cm_wchan | input | 5 | Output channel of the entry written |
| cm_wbyte | input | 8 | Connection word: message byte, or source stream in 7:5 and source channel in 4:0 |
| cm_wmsg | input | 1 | Message flag of the entry written |
| cm_wen | input | 1 | Driver enable flag of the entry written |
| rx_we | input | 1 | Received byte write strobe |
| rx_stream | input | 3 | Input stream of the received byte |
| rx_chan | input | 5 | Input channel of the received byte |
| rx_byte | input | 8 | Received byte |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle when valid |
| req_stream | input | 3 | Output stream looked up |
| req_chan | input | 5 | Output channel looked up |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_byte | output | 8 | Byte to transmit in the slot |
| rsp_drive | output | 1 | Driver enable for the slot |

## Verification
The checker tests four things on every cycle: the forced driver-off rule of the drive-enable pin, that a stalled response holds, the two-edge arrival of each accepted request, and the in-flight bound with its back-pressure on `req_ready`. Choosing between a message byte and a switched byte, following a source pointer, the global override of the stored flags, response order after a stall, and whether a newly received byte is seen can only be shown by the bench. Its scenarios preload the tables with known contents and compare each response with the value the requirements predict.

// File: rtl/otsw_pkg.sv
package otsw_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              msg;
    logic              en;
    logic [BYTE_W-1:0] word;
  } cm_entry_t;

  typedef struct packed {
    logic msg;
    logic en;
  } slot_ctrl_t;
endpackage

// File: rtl/otsw_regfile.sv
module otsw_regfile #(
  parameter int W     = 8,
  parameter int AW    = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/otsw_ctrl_resolve.sv
module otsw_ctrl_resolve
  import otsw_pkg::*;
(
  input  logic       msg_all,
  input  cm_entry_t  entry,
  output slot_ctrl_t eff
);
  // The global mode stands in for both stored flags of every slot.
  always_comb begin
    eff.msg = msg_all | entry.msg;
    eff.en  = msg_all | entry.en;
  end
endmodule

// File: rtl/otsw_out_ctrl.sv
module otsw_out_ctrl
  import otsw_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCHAN   = 32,
  localparam int SW     = $clog2(NSTREAM),
  localparam int CW     = $clog2(NCHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_all,
  input  logic              drive_en,
  input  logic              cm_we,
  input  logic [SW-1:0]     cm_wstream,
  input  logic [CW-1:0]     cm_wchan,
  input  logic [BYTE_W-1:0] cm_wbyte,
  input  logic              cm_wmsg,
  input  logic              cm_wen,
  input  logic              rx_we,
  input  logic [SW-1:0]     rx_stream,
  input  logic [CW-1:0]     rx_chan,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SW-1:0]     req_stream,
  input  logic [CW-1:0]     req_chan,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_byte,
  output logic              rsp_drive
);
  localparam int AW  = SW + CW;
  localparam int CMW = $bits(cm_entry_t);

  // Pipeline control: the whole chain stalls behind a held response.
  logic adv_out, adv_s1, req_fire;
  logic s1_valid;
  assign adv_out   = !rsp_valid || rsp_ready;
  assign adv_s1    = !s1_valid || adv_out;
  assign req_ready = adv_s1;
  assign req_fire  = req_valid && req_ready;

  // Connection table, one entry per output slot.
  cm_entry_t cm_wentry, cm_rentry;
  logic [CMW-1:0] cm_rbits;
  assign cm_wentry = '{msg: cm_wmsg, en: cm_wen, word: cm_wbyte};
  assign cm_rentry = cm_entry_t'(cm_rbits);

  otsw_regfile #(.W(CMW), .AW(AW)) u_cmem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cm_we),
    .waddr ({cm_wstream, cm_wchan}),
    .wdata (cm_wentry),
    .raddr ({req_stream, req_chan}),
    .rdata (cm_rbits)
  );

  slot_ctrl_t eff;
  otsw_ctrl_resolve u_resolve (
    .msg_all (msg_all),
    .entry   (cm_rentry),
    .eff     (eff)
  );

  // Stage 1: resolved control and connection word.
  logic [BYTE_W-1:0] s1_word;
  slot_ctrl_t        s1_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_word  <= '0;
      s1_ctrl  <= '0;
    end else if (adv_s1) begin
      s1_valid <= req_valid;
      if (req_fire) begin
        s1_word <= cm_rentry.word;
        s1_ctrl <= eff;
      end
    end
  end

  // Receive table, addressed by the stage-1 word as {stream, channel}.
  logic [BYTE_W-1:0] rx_rdata;
  logic [AW-1:0]     src_addr;
  assign src_addr = s1_word[AW-1:0];

  otsw_regfile #(.W(BYTE_W), .AW(AW)) u_rxmem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rx_we),
    .waddr ({rx_stream, rx_chan}),
    .wdata (rx_byte),
    .raddr (src_addr),
    .rdata (rx_rdata)
  );

  // Output stage.
  logic en_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_byte  <= '0;
      en_q      <= 1'b0;
    end else if (adv_out) begin
      rsp_valid <= s1_valid;
      if (s1_valid) begin
        rsp_byte <= s1_ctrl.msg ? s1_word : rx_rdata;
        en_q     <= s1_ctrl.en;
      end
    end
  end

  // The external pin overrides every stored or global setting at once.
  assign rsp_drive = drive_en & en_q;
endmodule

// File: rtl/otsw_out_ctrl_chk.sv
module otsw_out_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       drive_en,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_byte,
  input logic       rsp_drive
);
  logic [1:0] inflight;
  logic       acc, dlv;
  assign acc = req_valid && req_ready;
  assign dlv = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= 2'd0;
    else if (acc && !dlv) inflight <= inflight + 2'd1;
    else if (!acc && dlv) inflight <= inflight - 2'd1;
  end

  a_r5_pin_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> !rsp_drive);

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));

  a_r8_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ##1 rsp_valid);

  a_r8_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 2'd2);

  a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == 2'd2 && rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind otsw_out_ctrl otsw_out_ctrl_chk u_chk (.*);

// File: tb/test_otsw_out_ctrl.sv
module test_otsw_out_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_all = 1'b0, drive_en = 1'b1;
  logic cm_we = 1'b0, cm_wmsg = 1'b0, cm_wen = 1'b0;
  logic [2:0] cm_wstream = '0, rx_stream = '0, req_stream = '0;
  logic [4:0] cm_wchan = '0, rx_chan = '0, req_chan = '0;
  logic [7:0] cm_wbyte = '0, rx_byte = '0;
  logic rx_we = 1'b0, req_valid = 1'b0, rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_drive;
  logic [7:0] rsp_byte;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  otsw_out_ctrl i_otsw_out_ctrl (.*);

  // Vector: stream(3) chan(5) msg_all drive_en exp_byte(8) exp_drive
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 5'd1,  1'b0, 1'b1, 8'hC2, 1'b1},  // R3 switched, R7 enabled
    {3'd2, 5'd4,  1'b0, 1'b1, 8'h5C, 1'b1},  // R2 message
    {3'd7, 5'd31, 1'b0, 1'b1, 8'h5A, 1'b0},  // R3 switched, R7 disabled
    {3'd5, 5'd0,  1'b0, 1'b1, 8'h3A, 1'b0},  // R2 message, R7 disabled
    {3'd5, 5'd0,  1'b1, 1'b1, 8'h3A, 1'b1},  // R6 global drives
    {3'd1, 5'd2,  1'b1, 1'b1, 8'hC9, 1'b1},  // R4 pointer sent as message
    {3'd1, 5'd2,  1'b0, 1'b1, 8'h6C, 1'b1},  // R3 pointer followed
    {3'd2, 5'd4,  1'b0, 1'b0, 8'h5C, 1'b0},  // R5 pin low
    {3'd1, 5'd2,  1'b1, 1'b0, 8'hC9, 1'b0},  // R5 pin low beats global
    {3'd7, 5'd31, 1'b1, 1'b1, 8'hFF, 1'b1}   // R4 stored flags ignored
  };
  localparam string VREQ [NV] = '{"R3", "R2", "R7", "R2", "R6",
                                  "R4", "R3", "R5", "R5", "R4"};

  function automatic logic [7:0] rx_pat(input int s, input int c);
    return 8'(((s & 7) << 5) | (c & 31)) ^ 8'hA5;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cm_write(input int s, input int c, input logic [7:0] w,
                          input logic m, input logic e);
    @(negedge clk);
    cm_we = 1'b1; cm_wstream = 3'(s); cm_wchan = 5'(c);
    cm_wbyte = w; cm_wmsg = m; cm_wen = e;
    @(negedge clk);
    cm_we = 1'b0;
  endtask

  task automatic rx_write(input int s, input int c, input logic [7:0] b);
    @(negedge clk);
    rx_we = 1'b1; rx_stream = 3'(s); rx_chan = 5'(c); rx_byte = b;
    @(negedge clk);
    rx_we = 1'b0;
  endtask

  task automatic lookup(input int s, input int c, input logic m, input logic d,
                        output logic [7:0] b, output logic dr);
    @(negedge clk);
    req_valid = 1'b1; req_stream = 3'(s); req_chan = 5'(c);
    msg_all = m; drive_en = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 6 && !rsp_valid; k++) @(negedge clk);
    b = rsp_byte;
    dr = rsp_drive;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] b;
    logic dr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {31'd0, rsp_valid}, 32'd0);
    check("R1", {31'd0, req_ready}, 32'd1);
    lookup(4, 4, 1'b0, 1'b1, b, dr);
    check("R1", {24'd0, b}, 32'h00);
    check("R1", {31'd0, dr}, 32'd0);

    // Preload tables
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++) rx_write(s, c, rx_pat(s, c));
    cm_write(0, 1,  {3'd3, 5'd7},  1'b0, 1'b1);
    cm_write(2, 4,  8'h5C,         1'b1, 1'b1);
    cm_write(7, 31, {3'd7, 5'd31}, 1'b0, 1'b0);
    cm_write(5, 0,  8'h3A,         1'b1, 1'b0);
    cm_write(1, 2,  {3'd6, 5'd9},  1'b0, 1'b1);

    for (int v = 0; v < NV; v++) begin
      lookup(int'(VEC[v][18:16]), int'(VEC[v][15:11]), VEC[v][10], VEC[v][9], b, dr);
      check(VREQ[v], {24'd0, b}, {24'd0, VEC[v][8:1]});
      check(VREQ[v], {31'd0, dr}, {31'd0, VEC[v][0]});
    end

    // R10 a rewritten received byte is seen by a later switched lookup
    rx_write(3, 7, 8'h11);
    lookup(0, 1, 1'b0, 1'b1, b, dr);
    check("R10", {24'd0, b}, 32'h11);

    // R8 two-edge latency
    @(negedge clk);
    req_valid = 1'b1; req_stream = 3'd5; req_chan = 5'd0; msg_all = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    check("R8", {31'd0, rsp_valid}, 32'd1);
    check("R8", {24'd0, rsp_byte}, 32'h3A);
    @(negedge clk);

    // R9 back-pressure with two queued requests
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_stream = 3'd2; req_chan = 5'd4;
    @(negedge clk);
    req_stream = 3'd0; req_chan = 5'd1;
    @(negedge clk);
    req_stream = 3'd2; req_chan = 5'd4;
    check("R9", {31'd0, req_ready}, 32'd0);
    check("R9", {24'd0, rsp_byte}, 32'h5C);
    repeat (3) @(negedge clk);
    check("R9", {31'd0, rsp_valid}, 32'd1);
    check("R9", {24'd0, rsp_byte}, 32'h5C);
    // R5 pin drop acts at once on a held response
    check("R5", {31'd0, rsp_drive}, 32'd1);
    drive_en = 1'b0;
    #1 check("R5", {31'd0, rsp_drive}, 32'd0);
    drive_en = 1'b1;
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8", {24'd0, rsp_byte}, 32'h11);
    @(negedge clk);
    check("R8", {24'd0, rsp_byte}, 32'h5C);
    check("R8", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    check("R8", {31'd0, rsp_valid}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule